// File: doc/BRIEF.md
# SPI Memory-Access Transaction Master

This block drives a four-wire SPI link to a memory-mapped display coprocessor. A host hands it one request at a time through a valid/ready handshake. The block turns each request into a complete framed transaction, raises a one-cycle completion pulse, and for reads returns the assembled result. A request can be a register read or write of one, two or four bytes, a burst write of any byte count, or a three-byte host command.

Every memory access opens with a three-byte address header. Bit 7 of the first header byte marks a write. A read inserts one turnaround byte before the data phase. Multi-byte values travel low byte first, while the bits of each byte go out high bit first. During a burst, the payload bytes are pulled from the host one by one through a consume strobe.

The serial clock rate is set by a divider register. The register comes out of reset at a slow value, and the host may change it between transactions.

Top module: `spi_xact_master`

## Requirements
- R1: The link runs in SPI mode 0. spi_sclk is low whenever spi_cs_n is high. spi_mosi changes only while spi_sclk is low, and stays unchanged across each rising edge. spi_miso is sampled on the rising edge. Each byte is shifted high bit first.
- R2: A write (req_op=1) sends {1'b1,1'b0,addr[21:16]}, then addr[15:8], then addr[7:0], then the data bytes.
- R3: A read (req_op=0) sends {2'b00,addr[21:16]}, then addr[15:8], then addr[7:0], then one 0x00 turnaround byte. It then clocks in the data bytes while sending 0x00.
- R4: req_size selects the data length: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Reads and writes both move data low byte first.
- R5: spi_cs_n stays low for the whole transaction. Exactly eight rising spi_sclk edges occur per byte sent.
- R6: A host command (req_op=3) sends req_wdata[7:0], then 0x00, then 0x00, under a single chip-select assertion.
- R7: A burst (req_op=2) sends the write header, then req_len bytes taken from bst_byte. A req_len of 0 sends only the header. bst_pop pulses once for each byte taken, after the byte is latched.
- R8: After a read, rsp_rdata holds the received bytes, zero-extended to 32 bits. Other operations leave rsp_rdata unchanged.
- R9: req_ready is low from acceptance until the transaction has finished. rsp_done is a single-cycle pulse, issued in the cycle in which spi_cs_n rises.
- R10: Between transactions, spi_cs_n stays high for at least one half-period. req_valid asserted while busy is ignored and starts no transaction.
- R11: Each sclk half-period lasts div+1 clock cycles. div resets to DIV_RESET. A div_we pulse while idle loads div_wdata. A div_we pulse while busy, or in the cycle a request is accepted, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 read, 1 write, 2 burst write, 3 host command |
| req_addr | input | 22 | Target address |
| req_wdata | input | 32 | Write data, or command byte in bits [7:0] |
| req_size | input | 2 | Data length code for reads and writes |
| req_len | input | LEN_W | Burst byte count |
| bst_byte | input | 8 | Next burst payload byte |
| bst_pop | output | 1 | Burst byte consumed, present the next one |
| div_we | input | 1 | Load the clock divider |
| div_wdata | input | DIV_W | New divider value |
| rsp_rdata | output | 32 | Last read result |
| rsp_done | output | 1 | Transaction complete pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest case to reach from the ports is a request, or a divider write, that arrives while a transaction is in flight. The block must leave both untouched, and the only visible evidence is what does not happen later. The stimulus raises req_valid with a conflicting opcode, and pulses div_we, a few cycles after an acceptance. It then checks that exactly one frame appeared on the wire and that the next frame still runs at the old half-period. Burst lengths of zero, one and several dozen bytes are driven directly. Random mixes of all four operations and all size codes cover the rest, at a divider of zero, where rise and fall fall on consecutive cycles.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_BURST = 2'd2,
    OP_HCMD  = 2'd3
  } xop_e;

  // number of data bytes for a size code (3 behaves as 2)
  function automatic logic [15:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 16'd1;
      2'd1:    return 16'd2;
      default: return 16'd4;
    endcase
  endfunction

  // index of the final byte of a transaction
  function automatic logic [15:0] last_index(xop_e op, logic [1:0] sz, logic [15:0] len);
    case (op)
      OP_RD:    return 16'd3 + size_bytes(sz);
      OP_WR:    return 16'd2 + size_bytes(sz);
      OP_BURST: return 16'd2 + len;
      default:  return 16'd2;
    endcase
  endfunction

  // byte sent at position k (burst payload bytes are supplied elsewhere)
  function automatic logic [7:0] frame_byte(xop_e op, logic [21:0] a, logic [31:0] wd,
                                            logic [15:0] k);
    logic [7:0] b;
    logic [1:0] sel;
    b   = 8'h00;
    sel = k[1:0] + 2'd1;
    if (op == OP_HCMD) begin
      if (k == 16'd0) b = wd[7:0];
    end else begin
      case (k)
        16'd0:   b = {op != OP_RD, 1'b0, a[21:16]};
        16'd1:   b = a[15:8];
        16'd2:   b = a[7:0];
        default: if (op == OP_WR) b = wd[{sel, 3'b000} +: 8];
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // R11: a new run always starts a full half-period
  assert_restart_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       rise,
  input  logic       fall,
  input  logic       miso,
  output logic       mosi,
  output logic       byte_end,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q, rx_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else if (load) begin
      tx_q  <= load_byte;
      bit_q <= '0;
    end else begin
      if (rise) rx_q <= {rx_q[6:0], miso};
      if (fall) begin
        tx_q  <= {tx_q[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
      end
    end
  end

  assign mosi     = tx_q[7];
  assign byte_end = fall && (bit_q == 3'd7);
  assign rx_byte  = rx_q;
endmodule

// File: rtl/spi_xact_master.sv
module spi_xact_master
  import spi_xact_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [21:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [1:0]       req_size,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       bst_byte,
  output logic             bst_pop,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_done,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  localparam int IDX_W = 16;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);
  localparam logic [IDX_W-1:0] HDR_LEN  = 16'd3;
  localparam logic [IDX_W-1:0] RD_DATA0 = 16'd4;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_e;

  st_e              st_q;
  xop_e             op_q;
  logic [21:0]      addr_q;
  logic [31:0]      wd_q, rdata_q;
  logic [IDX_W-1:0] idx_q, last_q, nxt_idx;
  logic [DIV_W-1:0] div_q;
  logic             sclk_q, cs_n_q, done_q, pop_q;

  // named internal events
  logic       tick, rise, fall, byte_end, accept, advance, is_last, from_bst, capture, load;
  logic [7:0] rx_byte, nxt_byte, load_byte;

  assign accept   = req_valid && (st_q == S_IDLE);
  assign rise     = (st_q == S_XFER) && tick && !sclk_q;
  assign fall     = (st_q == S_XFER) && tick && sclk_q;
  assign is_last  = (idx_q == last_q);
  assign nxt_idx  = idx_q + 1'b1;
  assign advance  = byte_end && !is_last;
  assign from_bst = (op_q == OP_BURST) && (nxt_idx >= HDR_LEN);
  assign capture  = byte_end && (op_q == OP_RD) && (idx_q >= RD_DATA0);
  assign nxt_byte = from_bst ? bst_byte : frame_byte(op_q, addr_q, wd_q, nxt_idx);
  assign load     = accept || advance;
  assign load_byte = accept ? frame_byte(xop_e'(req_op), req_addr, req_wdata, '0) : nxt_byte;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(st_q != S_IDLE), .div(div_q), .tick(tick)
  );

  spi_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte), .rise(rise),
    .fall(fall), .miso(spi_miso), .mosi(spi_mosi), .byte_end(byte_end), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_RD;
      addr_q  <= '0;
      wd_q    <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      div_q   <= DIV_INIT;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      pop_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      pop_q  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            op_q   <= xop_e'(req_op);
            addr_q <= req_addr;
            wd_q   <= req_wdata;
            idx_q  <= '0;
            last_q <= last_index(xop_e'(req_op), req_size, IDX_W'(req_len));
            cs_n_q <= 1'b0;
            st_q   <= S_XFER;
            if (xop_e'(req_op) == OP_RD) rdata_q <= '0;
          end else if (div_we) begin
            div_q <= div_wdata;
          end
        end
        S_XFER: begin
          if (rise) sclk_q <= 1'b1;
          if (fall) begin
            sclk_q <= 1'b0;
            if (byte_end && is_last) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              st_q   <= S_GAP;
            end
          end
          if (advance) begin
            idx_q <= nxt_idx;
            pop_q <= from_bst;
          end
          if (capture) rdata_q[{idx_q[1:0], 3'b000} +: 8] <= rx_byte;
        end
        default: if (tick) st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign spi_sclk  = sclk_q;
  assign spi_cs_n  = cs_n_q;
  assign rsp_done  = done_q;
  assign bst_pop   = pop_q;
  assign rsp_rdata = rdata_q;

  // R1: clock parks low outside a transaction
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R1: data is settled before every rising edge
  assert_mosi_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  // R9: completion coincides with chip select release
  assert_done_at_csrise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(spi_cs_n));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R10: a frame starts only from an accepted handshake
  assert_start_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready));
  // R7: payload strobes appear only inside a burst
  assert_pop_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bst_pop |-> (!spi_cs_n && op_q == OP_BURST));
endmodule

// File: tb/sim_spi_xact_master.sv
module sim_spi_xact_master;
  localparam int CLK_NS    = 10;
  localparam int LEN_W     = 12;
  localparam int DIV_W     = 8;
  localparam int DIV_RESET = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0, req_size = '0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] bst_byte = '0;
  logic bst_pop, div_we = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic [31:0] rsp_rdata;
  logic rsp_done, spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  int cur_div = DIV_RESET;
  int gap_req = 0;

  spi_xact_master #(.LEN_W(LEN_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_len(req_len), .bst_byte(bst_byte), .bst_pop(bst_pop), .div_we(div_we),
    .div_wdata(div_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model: responds with a per-transaction pattern, records what it hears
  function automatic logic [7:0] spat(int t, int k);
    return 8'((t * 29 + k * 83 + 5) & 255);
  endfunction
  function automatic logic [7:0] bpat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  logic [7:0] rec [0:63];
  int nbytes = 0, nrise = 0, ntrans = 0, sbit = 0;
  logic [7:0] ssh = '0;
  logic cs_s = 1'b1, sclk_s = 1'b0;

  always @(spi_sclk or spi_cs_n) begin
    if (spi_cs_n === 1'b0 && cs_s === 1'b1) begin
      nbytes = 0; nrise = 0; sbit = 0;
      spi_miso = spat(ntrans, 0)[7];
    end else if (spi_cs_n === 1'b1 && cs_s === 1'b0) begin
      ntrans++;
    end
    cs_s = spi_cs_n;
    if (spi_cs_n === 1'b0 && spi_sclk === 1'b1 && sclk_s === 1'b0) begin
      ssh = {ssh[6:0], spi_mosi};
      nrise++; sbit++;
      if (sbit == 8) begin
        if (nbytes < 64) rec[nbytes] = ssh;
        nbytes++; sbit = 0;
      end
    end else if (spi_cs_n === 1'b0 && spi_sclk === 1'b0 && sclk_s === 1'b1) begin
      spi_miso = spat(ntrans, nbytes)[7 - sbit];
    end
    sclk_s = spi_sclk;
  end

  // monitors sampled between clock edges
  int dcount = 0, hicnt = 0, last_hi = 0, csh = 0, bidx = 0;
  logic cs_m = 1'b1;
  always @(negedge clk) begin
    if (rsp_done) dcount++;
    if (bst_pop) begin bidx++; bst_byte = bpat(bidx); end
    if (spi_sclk) hicnt++;
    else if (hicnt != 0) begin last_hi = hicnt; hicnt = 0; end
    if (spi_cs_n === 1'b0 && cs_m === 1'b1 && gap_req != 0)
      chk(csh >= gap_req, "R10", "chip-select high gap", csh, gap_req);
    if (spi_cs_n) csh++; else csh = 0;
    cs_m = spi_cs_n;
  end

  logic [7:0] exp_b [0:63];
  int exp_n;
  logic [31:0] prev_rd = '0;

  task automatic build(input int op, input logic [21:0] a, input logic [31:0] wd,
                       input int sz, input int len, output logic [31:0] erd);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    erd = '0;
    for (int i = 0; i < 64; i++) exp_b[i] = 8'h00;
    if (op == 3) begin
      exp_b[0] = wd[7:0]; exp_n = 3;
    end else begin
      exp_b[0] = 8'(a >> 16) | ((op == 0) ? 8'h00 : 8'h80);
      exp_b[1] = 8'(a >> 8);
      exp_b[2] = 8'(a);
      if (op == 0) begin
        exp_n = 4 + nb;
        for (int j = 0; j < nb; j++) erd = erd | (32'(spat(ntrans, 4 + j)) << (8 * j));
      end else if (op == 1) begin
        exp_n = 3 + nb;
        for (int j = 0; j < nb; j++) exp_b[3 + j] = 8'(wd >> (8 * j));
      end else begin
        exp_n = 3 + len;
        for (int j = 0; j < len; j++) exp_b[3 + j] = bpat(j);
      end
    end
  endtask

  task automatic run(input int op, input logic [21:0] a, input logic [31:0] wd,
                     input int sz, input int len, input bit noise, input string tag);
    logic [31:0] erd;
    int d0, t0, wait_n, bad_at;
    build(op, a, wd, sz, len, erd);
    d0 = dcount; t0 = ntrans;
    @(negedge clk);
    if (op == 2) begin bidx = 0; bst_byte = bpat(0); end
    req_op = 2'(op); req_addr = a; req_wdata = wd; req_size = 2'(sz);
    req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready low while busy", req_ready, 0);
    if (noise) begin
      @(negedge clk);
      req_op = 2'(3 - op); req_valid = 1'b1; div_we = 1'b1; div_wdata = 8'd9;
      repeat (3) @(negedge clk);
      req_valid = 1'b0; div_we = 1'b0;
    end
    wait_n = 0;
    while (dcount == d0 && wait_n < 20000) begin @(negedge clk); wait_n++; end
    while (!req_ready && wait_n < 20000) begin @(negedge clk); wait_n++; end
    gap_req = cur_div + 1;
    chk(dcount == d0 + 1, "R9", "one done pulse", dcount - d0, 1);
    chk(ntrans == t0 + 1, noise ? "R10" : "R5", "one frame per request", ntrans - t0, 1);
    chk(nbytes == exp_n && nrise == 8 * exp_n, "R5", "byte and edge count", nrise, 8 * exp_n);
    bad_at = -1;
    for (int i = 0; i < exp_n && i < 64; i++)
      if (bad_at < 0 && rec[i] !== exp_b[i]) bad_at = i;
    chk(bad_at < 0, tag, "frame bytes", (bad_at < 0) ? 0 : rec[bad_at],
        (bad_at < 0) ? 0 : exp_b[bad_at]);
    chk(last_hi == cur_div + 1, "R11", "sclk half-period", last_hi, cur_div + 1);
    if (op == 0) begin
      chk(rsp_rdata == erd, "R4", "read result low byte first, zero-extended", rsp_rdata, erd);
      prev_rd = erd;
    end else begin
      chk(rsp_rdata == prev_rd, "R8", "result untouched by non-read", rsp_rdata, prev_rd);
    end
    if (op == 2) chk(bidx == len, "R7", "burst pops", bidx, len);
  endtask

  task automatic set_div(input int v);
    @(negedge clk);
    div_we = 1'b1; div_wdata = DIV_W'(v);
    @(negedge clk);
    div_we = 1'b0;
    cur_div = v;
  endtask

  initial begin
    #(CLK_NS * 190000);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "reset pins idle", {spi_cs_n, spi_sclk}, 2);
    chk(req_ready == 1'b1 && rsp_done == 1'b0, "R9", "reset handshake", {req_ready, rsp_done}, 2);
    chk(rsp_rdata == 32'h0, "R8", "reset result", rsp_rdata, 0);
    // slow reset rate, 4-byte read (R3, R11)
    run(0, 22'h2A5C3E, 32'h0, 2, 0, 1'b0, "R3");
    set_div(1);
    run(1, 22'h3FFFFF, 32'hDEADBEEF, 2, 0, 1'b0, "R2");
    run(1, 22'h012345, 32'h0000A1B2, 1, 0, 1'b0, "R2");
    run(1, 22'h000000, 32'h000000C7, 0, 0, 1'b0, "R2");
    run(0, 22'h10F00D, 32'h0, 0, 0, 1'b0, "R3");
    run(0, 22'h0ABCDE, 32'h0, 1, 0, 1'b0, "R3");
    run(0, 22'h001234, 32'h0, 3, 0, 1'b0, "R4");
    run(3, 22'h3FFFFF, 32'hFFFFFF68, 0, 0, 1'b0, "R6");
    run(2, 22'h300000, 32'h0, 0, 0, 1'b0, "R7");
    run(2, 22'h123456, 32'h0, 0, 1, 1'b0, "R7");
    run(2, 22'h0C0000, 32'h0, 0, 37, 1'b0, "R7");
    // busy request and divider write must be ignored (R10, R11)
    run(0, 22'h055555, 32'h0, 2, 0, 1'b1, "R3");
    run(1, 22'h2AAAAA, 32'h11223344, 2, 0, 1'b0, "R2");
    set_div(0);
    for (int n = 0; n < 30; n++) begin
      int op = int'($urandom % 4);
      run(op, 22'($urandom), $urandom, int'($urandom % 4), int'($urandom % 40), 1'b0,
          (op == 0) ? "R3" : (op == 1) ? "R2" : (op == 2) ? "R7" : "R6");
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule